// File: doc/BRIEF.md
# Carry select adder with excess-one converters

This block is a wide binary adder of the carry-select kind. It adds two operands and a carry-in, and produces a sum and a carry-out. The operands are split into groups. The lowest group is a plain ripple adder fed by the real carry-in. Every higher group has two results ready before its incoming carry settles:

- A ripple adder computes the first result with its carry-in tied low.
- An increment-by-one converter derives the second result from the first. It works on the group's sum extended with the group's carry bit.

The true incoming carry then selects one of the two words. The top bit of the selected word is the carry passed to the next group.

The group sizes are a parameter list. The list may be uniform, or it may grow toward the most significant end. The sizes must add up to the operand width, and elaboration stops if they do not. A parameter chooses between a registered output and a purely combinational one. The registered output uses a synchronous, active-high reset. The default build is 128 bits wide, registered, with group sizes 4, 8, 12, 16, 20, 20, 24 and 24 from the least significant end. A 16-bit build with four groups of 4 bits uses the same structure.

Top module: `cssa_adder`

## Requirements
- R1: With the registered output, `{cout, sum}` equals the 129-bit value `a + b + cin` computed from the inputs present at the previous rising clock edge.
- R2: The registered result appears exactly one clock after the inputs are applied. Until that edge, the output keeps the previous result.
- R3: While `rst` is high at a rising edge, the register loads `sum = 0` and `cout = 0`, whatever the inputs are.
- R4: The carry-in enters only at the least significant bit. With `a = 0`, `b = 0` and `cin = 1`, the result is `sum = 1` and `cout = 0`.
- R5: Adding 1 to an all-ones `a` gives `sum = 0` and `cout = 1`.
- R6: A carry produced below any group boundary reaches the boundary bit. Let `k` be a boundary offset (4, 12, 24, 40, 60, 80 or 104 in the default build). Then `a = 2^k - 1` plus `b = 1` gives `sum = 2^k`.
- R7: A group whose carry-in-0 result is all ones in its sum bits turns to zero when its incoming carry is 1, and passes a carry upward. So an all-ones `a` with `b = 0` and `cin = 1` gives `sum = 0` and `cout = 1`. A carry-in to the same boundary value `2^k - 1` gives `sum = 2^k`.
- R8: With the output register disabled, a 16-bit build with four 4-bit groups presents `{cout, sum} = a + b + cin` in the same cycle the inputs change.
- R9: Zero plus zero with no carry-in gives `sum = 0` and `cout = 0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into the least significant bit |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the most significant group |

## Verification
In the registered build, the result of an input change is due at the first rising edge after the change. The bench changes the inputs on a falling edge and reads the result on the following falling edge, half a period after the register loads.

For the one-cycle latency check, the bench also reads the output shortly after driving new inputs. It confirms there that the old result is still held.

The combinational 16-bit build has no register in its path. It is read 1 ns after each input change, within the same cycle.

Reset is checked on the falling edge that follows a rising edge sampled with `rst` high.

// File: rtl/cssa_pkg.sv
package cssa_pkg;

  localparam int unsigned MAX_GROUPS = 16;

  typedef int unsigned size_list_t [MAX_GROUPS];

  // Bit position where group idx starts.
  function automatic int unsigned grp_offset(size_list_t s, int unsigned idx);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < MAX_GROUPS; k++) begin
      if (k < idx) acc += s[k];
    end
    return acc;
  endfunction

  // Total width covered by the first n groups.
  function automatic int unsigned grp_total(size_list_t s, int unsigned n);
    return grp_offset(s, n);
  endfunction

endpackage

// File: rtl/cssa_rca.sv
module cssa_rca #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] c;

  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]   = a[i] ^ b[i] ^ c[i];
    assign c[i+1]   = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end

  assign cout = c[W];

  // R1
  always_comb begin
    rca_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
      else $error("ripple stage result mismatch");
  end

endmodule

// File: rtl/cssa_inc.sv
module cssa_inc #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] b,
  output logic [W-1:0] x
);

  // run[i] is high when every bit below i is one.
  logic [W-1:0] run;

  assign run[0] = 1'b1;
  for (genvar i = 1; i < W; i++) begin : g_chain
    assign run[i] = run[i-1] & b[i-1];
  end

  assign x = b ^ run;

  // R7
  always_comb begin
    inc_step_chk: assert (W'(x - b) == W'(1))
      else $error("converter did not add one");
  end

endmodule

// File: rtl/cssa_group.sv
module cssa_group #(
  parameter int unsigned W     = 4,
  parameter bit          FIRST = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  if (FIRST) begin : g_low
    cssa_rca #(.W(W)) u_rca (
      .a   (a),
      .b   (b),
      .cin (cin),
      .sum (sum),
      .cout(cout)
    );
  end else begin : g_sel
    logic [W-1:0] s0;
    logic         c0;
    logic [W:0]   raw;
    logic [W:0]   bumped;

    cssa_rca #(.W(W)) u_rca (
      .a   (a),
      .b   (b),
      .cin (1'b0),
      .sum (s0),
      .cout(c0)
    );

    assign raw = {c0, s0};

    cssa_inc #(.W(W + 1)) u_inc (
      .b(raw),
      .x(bumped)
    );

    assign {cout, sum} = cin ? bumped : raw;

    // R7
    always_comb begin
      if (cin) begin
        group_no_wrap_chk: assert (!(&raw))
          else $error("carry-in-0 word cannot be all ones");
      end
    end
  end

endmodule

// File: rtl/cssa_adder.sv
module cssa_adder
  import cssa_pkg::*;
#(
  parameter int unsigned WIDTH       = 128,
  parameter int unsigned NUM_GROUPS  = 8,
  parameter size_list_t  GROUP_SIZES = '{4, 8, 12, 16, 20, 20, 24, 24,
                                         0, 0, 0, 0, 0, 0, 0, 0},
  parameter bit          REG_OUT     = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int unsigned COVERED = grp_total(GROUP_SIZES, NUM_GROUPS);

  if (NUM_GROUPS == 0 || NUM_GROUPS > MAX_GROUPS) begin : g_bad_count
    $error("group count out of range");
  end
  if (COVERED != WIDTH) begin : g_bad_sizes
    $error("group sizes do not add up to the operand width");
  end

  logic [NUM_GROUPS:0] carry;
  logic [WIDTH-1:0]    sum_c;

  assign carry[0] = cin;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int unsigned LO = grp_offset(GROUP_SIZES, g);
    localparam int unsigned GW = GROUP_SIZES[g];

    cssa_group #(.W(GW), .FIRST(g == 0)) u_grp (
      .a   (a[LO +: GW]),
      .b   (b[LO +: GW]),
      .cin (carry[g]),
      .sum (sum_c[LO +: GW]),
      .cout(carry[g+1])
    );
  end

  // R1
  always_comb begin
    total_sum_chk: assert ({carry[NUM_GROUPS], sum_c} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
      else $error("selected chain result mismatch");
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        sum  <= '0;
        cout <= 1'b0;
      end else begin
        sum  <= sum_c;
        cout <= carry[NUM_GROUPS];
      end
    end

    // R2
    reg_latency_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ({cout, sum} == $past({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin})))
      else $error("registered result not one cycle after inputs");

    // R3
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (sum == '0 && !cout))
      else $error("output not cleared by reset");
  end else begin : g_comb
    assign sum  = sum_c;
    assign cout = carry[NUM_GROUPS];
  end

endmodule

// File: tb/test_cssa_adder.sv
`timescale 1ns/1ps
module test_cssa_adder;
  import cssa_pkg::*;

  localparam int unsigned W  = 128;
  localparam int unsigned NW = 16;
  localparam int unsigned NV = 8;
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] ALT1 = {(W/2){2'b10}};
  localparam logic [W-1:0] ALT0 = {(W/2){2'b01}};

  localparam logic [W-1:0] TBL_A [NV] = '{'0, ONES, ONES, ALT1, ALT1, ALT0, '0, ONES};
  localparam logic [W-1:0] TBL_B [NV] = '{'0, W'(1), '0, ALT0, ALT1, ALT0, '0, ONES};
  localparam logic         TBL_C [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

  localparam int unsigned NB = 7;
  localparam int unsigned BOUNDS [NB] = '{4, 12, 24, 40, 60, 80, 104};

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [W-1:0]   a = '0;
  logic [W-1:0]   b = '0;
  logic           cin = 1'b0;
  logic [W-1:0]   sum;
  logic           cout;
  logic [NW-1:0]  sum_n;
  logic           cout_n;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cssa_adder #(
    .WIDTH(W), .NUM_GROUPS(8),
    .GROUP_SIZES('{4, 8, 12, 16, 20, 20, 24, 24, 0, 0, 0, 0, 0, 0, 0, 0}),
    .REG_OUT(1'b1)
  ) i_cssa_adder (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  cssa_adder #(
    .WIDTH(NW), .NUM_GROUPS(4),
    .GROUP_SIZES('{4, 4, 4, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}),
    .REG_OUT(1'b0)
  ) i_cssa_adder_narrow (
    .clk(clk), .rst(rst), .a(a[NW-1:0]), .b(b[NW-1:0]), .cin(cin),
    .sum(sum_n), .cout(cout_n)
  );

  task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb,
                       input logic vc, input string tag);
    logic [W:0]  exp;
    logic [NW:0] expn;
    exp  = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
    expn = {1'b0, va[NW-1:0]} + {1'b0, vb[NW-1:0]} + {{NW{1'b0}}, vc};
    @(negedge clk);
    a = va; b = vb; cin = vc;
    #1;
    check("R8 narrow same-cycle", {{(W-NW){1'b0}}, cout_n, sum_n}, {{(W-NW){1'b0}}, expn});
    @(negedge clk);
    check(tag, {cout, sum}, exp);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    a = ALT1; b = ALT0; cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 reset state", {cout, sum}, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(TBL_A[i], TBL_B[i], TBL_C[i], "R1 table");
    end

    apply('0, '0, 1'b0, "R9 zero plus zero");
    apply('0, '0, 1'b1, "R4 carry-in only");
    apply(ONES, W'(1), 1'b0, "R5 all ones plus one");
    apply(ONES, '0, 1'b1, "R7 carry-in through all groups");

    for (int k = 0; k < NB; k++) begin
      apply((W'(1) << BOUNDS[k]) - W'(1), W'(1), 1'b0, "R6 boundary carry");
      apply((W'(1) << BOUNDS[k]) - W'(1), '0, 1'b1, "R7 boundary via carry-in");
    end

    for (int i = 0; i < 60; i++) begin
      apply({$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom},
            1'($urandom), "R1 random");
    end

    // R2: the old result holds until the next rising edge
    apply(W'(5), W'(7), 1'b0, "R1 preload");
    @(negedge clk);
    a = W'(100); b = W'(23); cin = 1'b1;
    #1;
    check("R2 old result held", {cout, sum}, {1'b0, W'(12)});
    @(negedge clk);
    check("R2 one-cycle result", {cout, sum}, {1'b0, W'(124)});

    // R3: reset in mid-run clears the output
    a = ONES; b = ONES; cin = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R3 mid-run reset", {cout, sum}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 first result after reset", {cout, sum}, {1'b1, ONES});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule